// File: doc/BRIEF.md
# Four-Channel PS/2 Line Controller

This block gives firmware direct, bit-level control of four PS/2 ports. Every port has a clock line and a data line, both open-drain. A register bit of 0 pulls its pad low. A bit of 1 lets the pad float, so the external pull-up or the attached device sets the level. Firmware runs the PS/2 protocol by toggling these bits and by reading back the true line levels, which are synchronized first. Falling edges on the clock lines can raise a per-port interrupt. That interrupt drives firmware through each bit of a transfer.

There are two modes. In idle mode the output levels are frozen. A falling edge on either line of a port whose clock is released then raises a wake-up pulse and returns the block to active mode, so a device that starts a frame can wake the system. In shift mode a separate serial engine owns the lines. The pads are released and firmware output writes are refused.

The block is reached through a small register bus with four addresses:
- 0: line output bits. Clock bits are [3:0] and data bits are [7:4].
- 1: synchronized line levels, in the same layout as address 0.
- 2: interrupt control. Bit 7 is the enable and bits [3:0] are the pending flags.
- 3: mode. Bit 0 is shift mode and bit 1 is idle.

Top module: `ps2_line_port`

## Requirements
- R1: After reset, all eight output bits read as 1 at address 0 and no pad output-enable is asserted. The interrupt enable, the pending flags, both mode bits, every interrupt pulse and the wake output are all 0.
- R2: A write to address 0 takes effect on the next clock edge. Bit i in [3:0] drives clock pad i and bit 4+i drives data pad i. A 0 asserts that pad's output-enable and a 1 deasserts it. The pad output value is always 0.
- R3: Address 1 returns the line levels after a two-flop synchronizer, laid out as {data[3:0], clock[3:0]}. The value reflects the actual pad levels, including lines pulled low by an external device while the output bit is 1.
- R4: While interrupt enable (address 2 bit 7) is 1, a falling edge on clock pad i sets pending bit i. It also gives a one-cycle pulse on irqPulse[i] on the third clock edge after the pad changes. Data-line edges never raise interrupts, and clock edges raise nothing while the enable is 0.
- R5: A pending bit stays set until software writes 1 to it at address 2. Writing 0 leaves it unchanged. If a clear and a new falling edge on the same channel arrive in the same cycle, the bit stays set.
- R6: While idle (address 3 bit 1) is 1, writes to address 0 are ignored and the pad enables keep their values.
- R7: While shift mode (address 3 bit 0) is 1, all pad output-enables are deasserted and writes to address 0 are ignored. Leaving shift mode restores the stored output bits on the pads.
- R8: While idle, a falling edge on the clock or data line of a channel whose clock output bit is 1 gives a one-cycle wakeOut pulse and clears idle, on the third edge after the pad changes. Edges on a channel whose clock bit is 0 do not wake.
- R9: When firmware writes 0 to a clock output bit while that line is high, the resulting falling edge sets the channel's pending bit and pulses its interrupt when interrupts are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational on regAddr) |
| clkPadIn | input | 4 | Clock line levels from pads |
| datPadIn | input | 4 | Data line levels from pads |
| clkPadOut | output | 4 | Clock pad output value (always 0) |
| clkPadOe | output | 4 | Clock pad output enable (1 pulls low) |
| datPadOut | output | 4 | Data pad output value (always 0) |
| datPadOe | output | 4 | Data pad output enable (1 pulls low) |
| irqPulse | output | 4 | One-cycle interrupt pulse per channel |
| wakeOut | output | 1 | One-cycle wake-up pulse |

## Verification
Two functions can land in the same cycle: the software clear of a pending flag and the hardware set from a fresh clock falling edge on that channel. The bench pulls a clock line low on a falling clock edge. After two rising edges it issues the write-1-to-clear, so the write is sampled on the same edge that the edge detector sets the flag. It then reads the flag back and expects it still set. A plain clear with no edge must then leave it at 0.

// File: rtl/ps2_port_pkg.sv
package ps2_port_pkg;
  localparam int CH_NUM = 4;
  localparam int REG_W = 2 * CH_NUM;
  localparam int ADDR_W = 2;
  localparam int IRQ_EN_BIT = REG_W - 1;
  localparam int MODE_SHIFT_BIT = 0;
  localparam int MODE_IDLE_BIT = 1;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_LINES_OUT = 2'd0,
    ADDR_LINES_IN  = 2'd1,
    ADDR_IRQ       = 2'd2,
    ADDR_MODE      = 2'd3
  } reg_addr_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic              outWr;
    logic [CH_NUM-1:0] pendClr;
    logic              irqEn;
    logic              idle;
    logic              shiftEn;
  } ctrl_strobe_t;
endpackage

// File: rtl/ps2_port_sync.sv
module ps2_port_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= '1;
    else        stage[0] <= d;
  end

  generate
    for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[k] <= '1;
        else        stage[k] <= stage[k-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/ps2_port_ctrl.sv
module ps2_port_ctrl
  import ps2_port_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWdata,
  input  logic               wakeEvt,
  input  logic [REG_W-1:0]   outBits,
  input  logic [REG_W-1:0]   lineLevels,
  input  logic [CH_NUM-1:0]  pendBits,
  output logic [REG_W-1:0]   regRdata,
  output ctrl_strobe_t       strobe
);
  logic irqEnQ, idleQ, shiftEnQ;
  logic wrOut, wrIrq, wrMode;
  logic unusedWdata;

  assign unusedWdata = ^regWdata;

  assign wrOut  = regWe && (reg_addr_e'(regAddr) == ADDR_LINES_OUT);
  assign wrIrq  = regWe && (reg_addr_e'(regAddr) == ADDR_IRQ);
  assign wrMode = regWe && (reg_addr_e'(regAddr) == ADDR_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqEnQ   <= 1'b0;
      idleQ    <= 1'b0;
      shiftEnQ <= 1'b0;
    end else begin
      if (wrIrq)  irqEnQ   <= regWdata[IRQ_EN_BIT];
      if (wrMode) shiftEnQ <= regWdata[MODE_SHIFT_BIT];
      if (wakeEvt)     idleQ <= 1'b0;
      else if (wrMode) idleQ <= regWdata[MODE_IDLE_BIT];
    end
  end

  always_comb begin
    strobe.outWr   = wrOut && !idleQ && !shiftEnQ;
    strobe.pendClr = wrIrq ? regWdata[CH_NUM-1:0] : '0;
    strobe.irqEn   = irqEnQ;
    strobe.idle    = idleQ;
    strobe.shiftEn = shiftEnQ;
  end

  always_comb begin
    case (reg_addr_e'(regAddr))
      ADDR_LINES_OUT: regRdata = outBits;
      ADDR_LINES_IN:  regRdata = lineLevels;
      ADDR_IRQ:       regRdata = {irqEnQ, {(REG_W-1-CH_NUM){1'b0}}, pendBits};
      ADDR_MODE:      regRdata = {{(REG_W-2){1'b0}}, idleQ, shiftEnQ};
      default:        regRdata = '0;
    endcase
  end

  // R8
  wake_clears_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wakeEvt |=> !idleQ);

  // R4
  irq_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrIrq |=> $stable(irqEnQ));
endmodule

// File: rtl/ps2_port_dpath.sv
module ps2_port_dpath
  import ps2_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_strobe_t      strobe,
  input  logic [REG_W-1:0]  wdata,
  input  logic [CH_NUM-1:0] clkPadIn,
  input  logic [CH_NUM-1:0] datPadIn,
  output logic [CH_NUM-1:0] clkPadOut,
  output logic [CH_NUM-1:0] clkPadOe,
  output logic [CH_NUM-1:0] datPadOut,
  output logic [CH_NUM-1:0] datPadOe,
  output logic [CH_NUM-1:0] irqPulse,
  output logic              wakeOut,
  output logic              wakeEvt,
  output logic [REG_W-1:0]  outBits,
  output logic [REG_W-1:0]  lineLevels,
  output logic [CH_NUM-1:0] pendBits
);
  logic [REG_W-1:0]  outQ;
  logic [REG_W-1:0]  levelSync;
  logic [REG_W-1:0]  levelPrevQ;
  logic [REG_W-1:0]  fallAll;
  logic [CH_NUM-1:0] fallClk, fallDat;
  logic [CH_NUM-1:0] pendQ, irqQ;
  logic              wakeQ;
  logic [CH_NUM-1:0] irqSet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            outQ <= '1;
    else if (strobe.outWr) outQ <= wdata;
  end

  assign clkPadOe  = strobe.shiftEn ? '0 : ~outQ[CH_NUM-1:0];
  assign datPadOe  = strobe.shiftEn ? '0 : ~outQ[REG_W-1:CH_NUM];
  assign clkPadOut = '0;
  assign datPadOut = '0;

  ps2_port_sync #(.WIDTH(REG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({datPadIn, clkPadIn}),
    .q     (levelSync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) levelPrevQ <= '1;
    else        levelPrevQ <= levelSync;
  end

  assign fallAll = levelPrevQ & ~levelSync;
  assign fallClk = fallAll[CH_NUM-1:0];
  assign fallDat = fallAll[REG_W-1:CH_NUM];
  assign irqSet  = fallClk & {CH_NUM{strobe.irqEn}};

  // set has priority over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendQ <= '0;
      irqQ  <= '0;
    end else begin
      pendQ <= (pendQ & ~strobe.pendClr) | irqSet;
      irqQ  <= irqSet;
    end
  end

  assign wakeEvt = strobe.idle && |((fallClk | fallDat) & outQ[CH_NUM-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wakeQ <= 1'b0;
    else        wakeQ <= wakeEvt;
  end

  assign irqPulse   = irqQ;
  assign wakeOut    = wakeQ;
  assign outBits    = outQ;
  assign lineLevels = levelSync;
  assign pendBits   = pendQ;

  generate
    for (genvar i = 0; i < CH_NUM; i++) begin : g_chk
      // R4
      pend_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pendQ[i]) |-> $past(fallClk[i] && strobe.irqEn));

      // R4
      irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irqQ[i] |=> !irqQ[i]);

      // R5
      pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pendQ[i] && !strobe.pendClr[i]) |=> pendQ[i]);
    end
  endgenerate

  // R6
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.idle || strobe.shiftEn) |=> $stable(outQ));

  // R8
  wake_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wakeQ |-> $past(strobe.idle));
endmodule

// File: rtl/ps2_line_port.sv
module ps2_line_port
  import ps2_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic [CH_NUM-1:0] clkPadIn,
  input  logic [CH_NUM-1:0] datPadIn,
  output logic [CH_NUM-1:0] clkPadOut,
  output logic [CH_NUM-1:0] clkPadOe,
  output logic [CH_NUM-1:0] datPadOut,
  output logic [CH_NUM-1:0] datPadOe,
  output logic [CH_NUM-1:0] irqPulse,
  output logic              wakeOut
);
  ctrl_strobe_t      strobe;
  logic              wakeEvt;
  logic [REG_W-1:0]  outBits, lineLevels;
  logic [CH_NUM-1:0] pendBits;

  ps2_port_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .regWe      (regWe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .wakeEvt    (wakeEvt),
    .outBits    (outBits),
    .lineLevels (lineLevels),
    .pendBits   (pendBits),
    .regRdata   (regRdata),
    .strobe     (strobe)
  );

  ps2_port_dpath #(.SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .wdata      (regWdata),
    .clkPadIn   (clkPadIn),
    .datPadIn   (datPadIn),
    .clkPadOut  (clkPadOut),
    .clkPadOe   (clkPadOe),
    .datPadOut  (datPadOut),
    .datPadOe   (datPadOe),
    .irqPulse   (irqPulse),
    .wakeOut    (wakeOut),
    .wakeEvt    (wakeEvt),
    .outBits    (outBits),
    .lineLevels (lineLevels),
    .pendBits   (pendBits)
  );
endmodule

// File: tb/ps2_line_port_bench.sv
module ps2_line_port_bench;
  localparam int CLK_PERIOD = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       regWe = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic [3:0] clkPadOut, clkPadOe, datPadOut, datPadOe, irqPulse;
  logic       wakeOut;
  logic [3:0] devClkLow = '0;
  logic [3:0] devDatLow = '0;
  logic [3:0] clkLine, datLine;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // open-drain bus: any driver pulls low
  assign clkLine = ~clkPadOe & ~devClkLow;
  assign datLine = ~datPadOe & ~devDatLow;

  ps2_line_port u_ps2_line_port (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .clkPadIn(clkLine), .datPadIn(datLine),
    .clkPadOut(clkPadOut), .clkPadOe(clkPadOe),
    .datPadOut(datPadOut), .datPadOe(datPadOe),
    .irqPulse(irqPulse), .wakeOut(wakeOut)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    @(negedge clk);
    rd(2'd0, v); chk("R1 out bits", v, 8'hFF);
    rd(2'd2, v); chk("R1 irq reg", v, 8'h00);
    rd(2'd3, v); chk("R1 mode reg", v, 8'h00);
    chk("R1 pad oe", {datPadOe, clkPadOe}, 8'h00);
    chk("R1 irq/wake", {3'b0, wakeOut, irqPulse}, 8'h00);
  endtask

  task automatic t_drive;
    logic [7:0] v;
    wr(2'd0, 8'h5A);
    chk("R2 oe after write", {datPadOe, clkPadOe}, 8'hA5);
    chk("R2 pad out zero", {datPadOut, clkPadOut}, 8'h00);
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(2'd1, v); chk("R3 levels follow outputs", v, 8'h5A);
    devDatLow[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(2'd1, v); chk("R3 external pull seen", v, 8'h4A);
    devDatLow = '0;
    wr(2'd0, 8'hFF);
    chk("R2 release", {datPadOe, clkPadOe}, 8'h00);
    settle(4);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    wr(2'd2, 8'h80);
    devClkLow[1] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R4 no pulse before third edge", {4'b0, irqPulse}, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R4 pulse on third edge", {4'b0, irqPulse}, 8'h02);
    rd(2'd2, v); chk("R4 pending set", v, 8'h82);
    @(negedge clk);
    chk("R4 pulse one cycle", {4'b0, irqPulse}, 8'h00);
    devDatLow[2] = 1'b1;
    settle(5);
    rd(2'd2, v); chk("R4 data edge no irq", v, 8'h82);
    devClkLow = '0; devDatLow = '0;
    settle(4);
    wr(2'd2, 8'h0F);
    rd(2'd2, v); chk("R4 disabled and cleared", v, 8'h00);
    devClkLow[0] = 1'b1;
    settle(5);
    rd(2'd2, v); chk("R4 no pending when disabled", v, 8'h00);
    devClkLow = '0;
    settle(4);
  endtask

  task automatic t_clear;
    logic [7:0] v;
    wr(2'd2, 8'h80);
    devClkLow[0] = 1'b1;
    settle(5);
    rd(2'd2, v); chk("R5 set", v, 8'h81);
    devClkLow = '0;
    settle(5);
    wr(2'd2, 8'h80);
    rd(2'd2, v); chk("R5 write 0 keeps", v, 8'h81);
    // same-cycle clear and new edge
    @(negedge clk);
    devClkLow[0] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(2'd2, 8'h81);
    rd(2'd2, v); chk("R5 set wins over clear", v, 8'h81);
    devClkLow = '0;
    settle(4);
    wr(2'd2, 8'h81);
    rd(2'd2, v); chk("R5 clear", v, 8'h80);
  endtask

  task automatic t_self_edge;
    logic [7:0] v;
    wr(2'd0, 8'hF7);
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R9 self edge pulse", {4'b0, irqPulse}, 8'h08);
    rd(2'd2, v); chk("R9 self edge pending", v, 8'h88);
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'h0F);
    settle(4);
  endtask

  task automatic t_idle;
    logic [7:0] v;
    wr(2'd3, 8'h02);
    rd(2'd3, v); chk("R6 idle entered", v, 8'h02);
    wr(2'd0, 8'h00);
    chk("R6 oe unchanged", {datPadOe, clkPadOe}, 8'h00);
    rd(2'd0, v); chk("R6 out bits unchanged", v, 8'hFF);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_shift;
    logic [7:0] v;
    wr(2'd0, 8'hEE);
    chk("R2 oe pattern", {datPadOe, clkPadOe}, 8'h11);
    wr(2'd3, 8'h01);
    chk("R7 pads released", {datPadOe, clkPadOe}, 8'h00);
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk("R7 write ignored", v, 8'hEE);
    wr(2'd3, 8'h00);
    chk("R7 restored", {datPadOe, clkPadOe}, 8'h11);
    wr(2'd0, 8'hFF);
    settle(4);
  endtask

  task automatic t_wake;
    logic [7:0] v;
    int seen;
    wr(2'd0, 8'hFB);
    settle(4);
    wr(2'd3, 8'h02);
    devDatLow[2] = 1'b1;
    seen = 0;
    repeat (6) begin
      @(negedge clk);
      if (wakeOut) seen++;
    end
    chk("R8 held channel no wake", seen[7:0], 8'h00);
    rd(2'd3, v); chk("R8 still idle", v, 8'h02);
    @(negedge clk);
    devDatLow[1] = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R8 wake on data edge", {7'b0, wakeOut}, 8'h01);
    rd(2'd3, v); chk("R8 idle cleared", v, 8'h00);
    @(negedge clk);
    chk("R8 wake one cycle", {7'b0, wakeOut}, 8'h00);
    wr(2'd3, 8'h02);
    devClkLow[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R8 wake on clock edge", {7'b0, wakeOut}, 8'h01);
    devClkLow = '0; devDatLow = '0;
    wr(2'd0, 8'hFF);
    settle(4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_drive();
    t_irq();
    t_clear();
    t_self_edge();
    t_idle();
    t_shift();
    t_wake();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end
endmodule